// File: doc/BRIEF.md
# Compare Status-Flag Unit

This block works out the six arithmetic status flags that an integer compare produces. A compare is a subtraction whose difference is thrown away and whose status is kept. The unit takes two operands of up to 64 bits, a two-bit width code, a flag that marks the second operand as a byte-sized immediate, and the current 64-bit status word. It returns that word with the carry, parity, half-carry, zero, sign and overflow bits replaced. Every other bit of the word is returned as it came in.

The operands are first trimmed to the selected width: 8, 16, 32 or 64 bits. When the immediate flag is set, the low byte of the second operand is sign-extended to the selected width before the subtraction. Carry and half-carry both come from a single borrow vector. Parity folds the low byte of the difference into a nibble and looks that nibble up in a 16-entry table. Sign, zero, carry and overflow are all taken at the selected width.

A parameter adds an output register. With it, a valid strobe produces the updated word and a valid pulse one clock later, and the registered word holds between strobes. Instruction decode, operand fetch and memory access are not part of this block.

Top module: `cmp_flags_unit`

## Requirements
- R1: The difference is operand A minus operand B, wrapping, taken at the width given by size_i (2'b00 = 8 bits, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64). Carry (bit 0) is the borrow out of the width's top bit, so it is set exactly when the trimmed A is less than the trimmed B as unsigned numbers.
- R2: Half-carry (bit 4) is the borrow out of bit 3 at every width, so it is set exactly when A[3:0] < B[3:0] as unsigned numbers.
- R3: Parity (bit 2) is set when the low byte of the difference holds an even number of ones.
- R4: Zero (bit 6) is set when every difference bit below the width is zero. Sign (bit 7) is the difference bit at the width's top position.
- R5: Overflow (bit 11) is set when the operands' signs at the width differ and the sign of the difference differs from the sign of operand A.
- R6: Every status-word bit other than bits 0, 2, 4, 6, 7 and 11 is copied unchanged from flags_i.
- R7: Operand bits above the selected width have no effect on any flag. For example, a 32-bit compare of 0 against 0x8000_0000_0000_0000 gives zero and parity set (0x44), the same as 0 against 0.
- R8: With imm_byte_i high, B[7:0] is sign-extended to the selected width and B[63:8] is ignored. A 32-bit compare of 0x00AB_CDEF against 0xFF gives carry and parity only (0x05).
- R9: With the output register, valid_o rises one clock after valid_i and flags_o then carries the result for the inputs of that strobe. Without a strobe, flags_o keeps its value.
- R10: A synchronous active-high reset clears flags_o to zero and valid_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input strobe; operands and status word are taken this cycle |
| size_i | input | 2 | Width code: 00=8, 01=16, 10=32, 11=64 bits |
| imm_byte_i | input | 1 | Operand B is a byte immediate to sign-extend |
| opa_i | input | 64 | Operand A (minuend) |
| opb_i | input | 64 | Operand B (subtrahend) |
| flags_i | input | 64 | Incoming status word |
| valid_o | output | 1 | Result strobe |
| flags_o | output | 64 | Updated status word |

## Verification
Some properties are checked by the assertions on every cycle:
- the non-status bits of the word are carried through unchanged;
- a result with zero set never also shows carry, sign, overflow or half-carry, and always shows parity;
- the one-cycle strobe latency;
- the hold of the output between strobes;
- the cleared state after reset.

The exact value of each flag at each width is shown only by the bench's scenarios, which compare against a separate unsigned/signed comparison model. The same holds for the claim that upper operand bits have no effect, and for the sign extension of a byte immediate.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  localparam int WORD_W = 64;

  // Status-word bit positions
  localparam int CF_BIT = 0;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  localparam logic [WORD_W-1:0] STATUS_MASK =
    (WORD_W'(1) << CF_BIT) | (WORD_W'(1) << PF_BIT) | (WORD_W'(1) << AF_BIT) |
    (WORD_W'(1) << ZF_BIT) | (WORD_W'(1) << SF_BIT) | (WORD_W'(1) << OF_BIT);

  // Bit n is set when nibble value n has an even count of ones
  localparam logic [15:0] NIBBLE_EVEN_LUT = 16'h9669;

  localparam int NUM_SIZES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } opsize_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic hcy;
    logic par;
    logic cry;
  } status_t;

endpackage

// File: rtl/cmpf_operand_prep.sv
module cmpf_operand_prep
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  opsize_e           size_i,
  input  logic              imm_byte_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o,
  output logic [DATA_W-1:0] mask_o
);

  logic [DATA_W-1:0] mask_tbl [NUM_SIZES];
  logic [DATA_W-1:0] opb_ext;

  // One lane mask per width code
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    localparam int LANE_W = 8 << g;
    if (LANE_W >= DATA_W) begin : g_full
      assign mask_tbl[g] = '1;
    end else begin : g_part
      assign mask_tbl[g] = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    end
  end

  assign mask_o  = mask_tbl[size_i];
  assign opb_ext = imm_byte_i ? {{(DATA_W-8){opb_i[7]}}, opb_i[7:0]} : opb_i;
  assign opa_o   = opa_i & mask_o;
  assign opb_o   = opb_ext & mask_o;

endmodule

// File: rtl/cmpf_flag_core.sv
module cmpf_flag_core
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  opsize_e           size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] mask_i,
  output status_t           st_o
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] borrow;
  logic [DATA_W-1:0] ovf_vec;
  logic [IDX_W-1:0]  top;
  logic [3:0]        fold;

  assign diff    = a_i - b_i;
  assign borrow  = (~a_i & b_i) | (~(a_i ^ b_i) & diff);
  assign ovf_vec = (a_i ^ b_i) & (a_i ^ diff);
  assign fold    = diff[7:4] ^ diff[3:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  top = IDX_W'(7);
      SZ_HALF:  top = IDX_W'(15);
      SZ_WORD:  top = IDX_W'(31);
      default:  top = IDX_W'(DATA_W-1);
    endcase
  end

  always_comb begin
    st_o.cry = borrow[top];
    st_o.hcy = borrow[3];
    st_o.par = NIBBLE_EVEN_LUT[fold];
    st_o.zro = ((diff & mask_i) == '0);
    st_o.sgn = diff[top];
    st_o.ovf = ovf_vec[top];
  end

endmodule

// File: rtl/cmpf_flag_merge.sv
module cmpf_flag_merge
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] flags_i,
  input  status_t           st_i,
  output logic [DATA_W-1:0] flags_o
);

  always_comb begin
    flags_o         = flags_i;
    flags_o[CF_BIT] = st_i.cry;
    flags_o[PF_BIT] = st_i.par;
    flags_o[AF_BIT] = st_i.hcy;
    flags_o[ZF_BIT] = st_i.zro;
    flags_o[SF_BIT] = st_i.sgn;
    flags_o[OF_BIT] = st_i.ovf;
  end

endmodule

// File: rtl/cmp_flags_unit.sv
module cmp_flags_unit
  import cmpf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              imm_byte_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] flags_o
);

  opsize_e           size_e;
  logic [DATA_W-1:0] a_trim;
  logic [DATA_W-1:0] b_trim;
  logic [DATA_W-1:0] lane_mask;
  status_t           st;
  logic [DATA_W-1:0] flags_next;

  assign size_e = opsize_e'(size_i);

  cmpf_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .size_i     (size_e),
    .imm_byte_i (imm_byte_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .opa_o      (a_trim),
    .opb_o      (b_trim),
    .mask_o     (lane_mask)
  );

  cmpf_flag_core #(.DATA_W(DATA_W)) u_core (
    .size_i (size_e),
    .a_i    (a_trim),
    .b_i    (b_trim),
    .mask_i (lane_mask),
    .st_o   (st)
  );

  cmpf_flag_merge #(.DATA_W(DATA_W)) u_merge (
    .flags_i (flags_i),
    .st_i    (st),
    .flags_o (flags_next)
  );

  if (REGISTERED) begin : g_reg
    logic [DATA_W-1:0] flags_q;
    logic              valid_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) flags_q <= flags_next;
      end
    end
    assign flags_o = flags_q;
    assign valid_o = valid_q;
  end else begin : g_comb
    assign flags_o = flags_next;
    assign valid_o = valid_i;
  end

endmodule

// File: rtl/cmpf_checker.sv
module cmpf_checker
  import cmpf_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [DATA_W-1:0] flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] flags_o
);

  localparam logic [DATA_W-1:0] KEEP = ~DATA_W'(STATUS_MASK);

  // R4: an all-zero difference implies no borrow, positive sign, no overflow, even parity
  assert_zero_consistent_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && flags_o[ZF_BIT]) |->
      (!flags_o[CF_BIT] && !flags_o[SF_BIT] && !flags_o[OF_BIT] &&
       !flags_o[AF_BIT] && flags_o[PF_BIT]));

  if (REGISTERED) begin : g_reg_chk
    assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (((flags_o ^ $past(flags_i)) & KEEP) == '0));

    assert_strobe_latency_R9: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o);

    assert_no_spurious_strobe_R9: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !valid_o);

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(flags_o));

    assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (flags_o == '0 && !valid_o));
  end else begin : g_comb_chk
    assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
      valid_i |-> (((flags_o ^ flags_i) & KEEP) == '0));
  end

endmodule

bind cmp_flags_unit cmpf_checker #(
  .DATA_W     (DATA_W),
  .REGISTERED (REGISTERED)
) u_cmpf_checker (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .flags_i (flags_i),
  .valid_o (valid_o),
  .flags_o (flags_o)
);

// File: tb/test_cmp_flags_unit.sv
module test_cmp_flags_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SMASK = 64'h8D5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic        imm_byte_i = 1'b0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] flags_i = '0;
  logic        valid_o;
  logic [63:0] flags_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_flags_unit i_cmp_flags_unit (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .size_i     (size_i),
    .imm_byte_i (imm_byte_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .flags_i    (flags_i),
    .valid_o    (valid_o),
    .flags_o    (flags_o)
  );

  // Independent model: unsigned/signed comparisons instead of a borrow vector
  function automatic logic [63:0] model(input logic [1:0] sz, input logic immb,
                                        input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] fin);
    int w = 8 << sz;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] bx = immb ? {{56{b[7]}}, b[7:0]} : b;
    logic [63:0] aw = a & m;
    logic [63:0] bw = bx & m;
    logic [63:0] r = (aw - bw) & m;
    logic cf = aw < bw;
    logic af = aw[3:0] < bw[3:0];
    logic zf = (r == 0);
    logic sf = r[w-1];
    logic pf = ~^r[7:0];
    logic of = (aw[w-1] != bw[w-1]) && (sf != aw[w-1]);
    logic [63:0] st = {52'd0, of, 3'd0, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, cf};
    return (fin & ~SMASK) | st;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one strobe, expected word pushed to the scoreboard
  task automatic drive(input logic [1:0] sz, input logic immb, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] fin,
                       input logic [63:0] exp, input string req);
    @(negedge clk);
    size_i = sz; imm_byte_i = immb; opa_i = a; opb_i = b; flags_i = fin;
    valid_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // Monitor: pops one expected word per result strobe
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected strobe", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), flags_o, exp_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset flags", flags_o, 64'd0);
    check("R10 reset valid", {63'd0, valid_o}, 64'd0);
    rst = 1'b0;

    // R1 R3 R5 R4 directed vectors (values at masked bits)
    drive(2'b11, 1'b0, 64'h0, 64'h101, 64'h0, 64'h95, "R1 64b 0-0x101");
    drive(2'b11, 1'b0, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h885, "R5 64b overflow");
    drive(2'b11, 1'b0, '1, 64'h0, 64'h0, 64'h84, "R4 64b sign");
    drive(2'b10, 1'b0, 64'h1234_ABCD, 64'hDEAD_BEEF, 64'h0, 64'h15, "R3 32b parity");
    drive(2'b10, 1'b0, '1, 64'hDEAD_BEEF, 64'h0, 64'h0, "R7 32b upper ones");
    drive(2'b10, 1'b0, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h44, "R7 32b upper ignored");
    // R8 byte immediate
    drive(2'b10, 1'b1, 64'h00AB_CDEF, 64'hFFFF_FF00_0000_00FF, 64'h0, 64'h05, "R8 imm 0xFF");
    drive(2'b10, 1'b1, 64'h00AB_CDEF, 64'h64, 64'h0, 64'h04, "R8 imm 100");
    // R2 half-carry at byte width
    drive(2'b00, 1'b0, 64'h10, 64'h01, 64'h0, 64'h14, "R2 half borrow");
    drive(2'b00, 1'b0, 64'hFF00, 64'h1200, 64'h0, 64'h44, "R4 8b zero");
    // R6 passthrough of non-status bits
    drive(2'b01, 1'b0, 64'h7FFF, 64'h8000, '1, (~SMASK) | 64'h885, "R6 keep others");
    drive(2'b01, 1'b0, 64'h5, 64'h5, 64'hA5A5_5A5A_F00F_F72A, (64'hA5A5_5A5A_F00F_F72A & ~SMASK) | 64'h44, "R6 pattern");

    // Randomised vectors against the model
    for (int i = 0; i < 200; i++) begin
      logic [1:0]  s = 2'($urandom);
      logic        ib = 1'($urandom);
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [63:0] f = {$urandom, $urandom};
      if (i % 7 == 0) b = a ^ {$urandom, 32'h0};
      drive(s, ib, a, b, f, model(s, ib, a, b, f), "R1 random");
    end

    // R9 hold between strobes
    @(negedge clk);
    held = flags_o;
    opa_i = 64'h1; opb_i = 64'h2; flags_i = '1;
    repeat (4) @(negedge clk);
    check("R9 hold idle", flags_o, held);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule